// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns a one-bit delta-sigma bitstream into signed 16-bit words at a rate 512 times slower than the bitstream. Its response is the cube of a 512-tap boxcar. The first response null therefore sits at the output word rate, and the other nulls sit at whole multiples of it. The filter is built as a cascaded integrator-comb. Three running-sum stages update on every accepted bit. Three differencing stages update once per decimated word.

A synchronisation pulse clears every stage and restarts the decimation count. Once it has been given, the output settles within three word periods. A step that arrives at an arbitrary moment can take up to four periods to settle. A valid flag marks the words whose full impulse response lies after the most recent restart.

Each output word comes with a one-cycle ready strobe. A rate-select input chooses between two decimation settings, and both default to 512. Changing the rate-select level counts as a restart.

The restart tracker is a four-state machine:
- `S_WAIT1` means no word has been emitted since the restart.
- `S_WAIT2` means one word has been emitted.
- `S_WAIT3` means two words have been emitted.
- `S_LIVE` means the filter has settled.

Each emitted word advances the machine one state: `S_WAIT1`→`S_WAIT2`, then `S_WAIT2`→`S_WAIT3`, then `S_WAIT3`→`S_LIVE`. After that, `S_LIVE` holds. A restart sends any state back to `S_WAIT1`.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is applied and after it is released, `dout` is 0, `drdy` is 0 and `dvalid` is 0 until the first word is emitted.
- R2: Bit value 1 counts as +1 and bit value 0 counts as −1. A settled stream of all ones gives 32767 (0x7FFF, saturated). A settled stream of all zeros gives −32768 (0x8000).
- R3: The full result is the triple 512-sample boxcar sum of the mapped bits. The sum covers the samples up to and including the sample that ends the decimation period, with zero assumed before the last restart. `dout` is that sum arithmetically shifted right by 12, then saturated to the signed 16-bit range.
- R4: `drdy` is high for exactly one cycle per 512 accepted samples. It is high in the second cycle after the cycle in which the 512th strobe is sampled, and `dout` changes only at that point.
- R5: A high `fsync` clears all filter state and the decimation count. A sample strobe given in the same cycle as `fsync` is discarded, so sample counting restarts from the next strobe.
- R6: `dvalid` goes low in the cycle after a restart. It stays low for the first two words after the restart and goes high with the third word.
- R7: A change in the `rate_sel` level restarts the filter exactly as `fsync` does.
- R8: Cycles with `sample_en` low change neither the filter state nor the count, so idle gaps between strobes do not alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Strobe marking a valid modulator bit |
| mod_bit | input | 1 | Modulator bitstream bit |
| rate_sel | input | 1 | Selects one of two decimation settings; a level change restarts the filter |
| fsync | input | 1 | Synchronous restart pulse |
| dout | output | 16 | Decimated signed output word |
| drdy | output | 1 | One-cycle strobe for a new output word |
| dvalid | output | 1 | High when the current word is fully settled |

## Verification
Constant streams of ones and then of zeros exercise the positive and negative ends of the DC gain, including the saturation of the positive extreme. A pseudo-random bitstream with irregular idle gaps tests the exact triple-boxcar arithmetic and shows that gaps are invisible. A step left unsynchronised is followed by a patterned stream after a restart. In the unsynchronised case `dvalid` stays high while the reference model tracks the slow settling. A restart given together with a strobe, and a toggle of `rate_sel`, each show that the strobe is dropped and that `dvalid` falls and then reappears on the third word.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int ORDER = 3;

    typedef enum logic [1:0] {
        S_WAIT1,
        S_WAIT2,
        S_WAIT3,
        S_LIVE
    } settle_state_e;

endpackage

// File: rtl/sinc3_integrator.sv
module sinc3_integrator #(
    parameter int W      = 29,
    parameter int STAGES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                bit_i,
    output logic signed [W-1:0] last_o
);

    logic signed [W-1:0] acc_q [STAGES];
    logic signed [W-1:0] sum_d [STAGES];
    logic signed [W-1:0] step;

    // map the modulator bit onto +1 / -1
    always_comb begin
        step = bit_i ? W'(1) : {W{1'b1}};
    end

    // each stage adds the freshly updated value of the stage before it
    always_comb begin
        sum_d[0] = acc_q[0] + step;
        for (int s = 1; s < STAGES; s++) begin
            sum_d[s] = acc_q[s] + sum_d[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    acc_q[g] <= '0;
                end else if (en) begin
                    acc_q[g] <= sum_d[g];
                end
            end
        end
    endgenerate

    assign last_o = sum_d[STAGES-1];

    // R8: idle cycles leave the last running sum untouched
    a_r8_integrator_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(acc_q[STAGES-1]));

    // R5: a clear empties the first running sum
    a_r5_integrator_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q[0] == '0));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int W      = 29,
    parameter int STAGES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic signed [W-1:0] i3_in,
    input  logic                emit,
    output logic signed [W-1:0] res_o
);

    logic signed [W-1:0] samp_q;
    logic signed [W-1:0] dly_q  [STAGES];
    logic signed [W-1:0] diff_d [STAGES];

    // differencing chain over the decimated samples
    always_comb begin
        diff_d[0] = samp_q - dly_q[0];
        for (int s = 1; s < STAGES; s++) begin
            diff_d[s] = diff_d[s-1] - dly_q[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            samp_q <= '0;
        end else if (load) begin
            samp_q <= i3_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dly_q[0] <= '0;
        end else if (emit) begin
            dly_q[0] <= samp_q;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_delay
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    dly_q[g] <= '0;
                end else if (emit) begin
                    dly_q[g] <= diff_d[g-1];
                end
            end
        end
    endgenerate

    assign res_o = diff_d[STAGES-1];

    // R3: the decimated sample only moves at a decimation point
    a_r3_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(samp_q));

    // R5: the delays are emptied by a restart
    a_r5_comb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dly_q[STAGES-1] == '0));

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int RATIO0 = 512,
    parameter int RATIO1 = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic rate_sel,
    input  logic fsync,
    output logic accept_o,
    output logic restart_o,
    output logic tick_o,
    output logic emit_o,
    output logic drdy_o,
    output logic dvalid_o
);

    localparam int RMAX  = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
    localparam int CNT_W = $clog2(RMAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             rs_q;
    logic             go_q;
    settle_state_e    state_q;
    settle_state_e    state_d;

    always_comb begin
        limit     = rate_sel ? CNT_W'(RATIO1 - 1) : CNT_W'(RATIO0 - 1);
        restart_o = fsync || (rate_sel != rs_q);
        accept_o  = sample_en && !restart_o;
        tick_o    = accept_o && (cnt_q == limit);
        emit_o    = go_q && !restart_o;
    end

    // decimation counter and rate-select history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rs_q  <= 1'b0;
            go_q  <= 1'b0;
        end else begin
            rs_q <= rate_sel;
            go_q <= tick_o;
            if (restart_o || tick_o) begin
                cnt_q <= '0;
            end else if (accept_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT1;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart_o) begin
            state_d = S_WAIT1;
        end else if (go_q) begin
            unique case (state_q)
                S_WAIT1: state_d = S_WAIT2;
                S_WAIT2: state_d = S_WAIT3;
                S_WAIT3: state_d = S_LIVE;
                S_LIVE:  state_d = S_LIVE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_o   <= 1'b0;
            dvalid_o <= 1'b0;
        end else begin
            drdy_o <= emit_o;
            if (restart_o) begin
                dvalid_o <= 1'b0;
            end else if (go_q) begin
                unique case (state_q)
                    S_WAIT1, S_WAIT2: dvalid_o <= 1'b0;
                    S_WAIT3, S_LIVE:  dvalid_o <= 1'b1;
                endcase
            end
        end
    end

    // R4: ready lasts a single cycle
    a_r4_drdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |=> !drdy_o);

    // R4: a surviving decimation point yields ready on the next edge
    a_r4_emit_to_drdy: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |=> drdy_o);

    // R6: sync drops the valid flag
    a_r6_sync_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !dvalid_o);

    // R6: valid can only rise together with a new word
    a_r6_valid_rises_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid_o) |-> drdy_o);

    // R5: sync zeroes the count and cancels a pending word
    a_r5_sync_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cnt_q == '0 && !go_q));

    // R8: idle cycles do not advance the count
    a_r8_count_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !restart_o) |=> $stable(cnt_q));

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int RATIO0 = 512,
    parameter int RATIO1 = 512,
    parameter int OUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             mod_bit,
    input  logic             rate_sel,
    input  logic             fsync,
    output logic [OUT_W-1:0] dout,
    output logic             drdy,
    output logic             dvalid
);

    localparam int RMAX = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
    localparam int LOG2 = $clog2(RMAX);
    localparam int W    = ORDER * LOG2 + 2;
    localparam int SH0  = ORDER * $clog2(RATIO0) - (OUT_W - 1);
    localparam int SH1  = ORDER * $clog2(RATIO1) - (OUT_W - 1);

    logic                accept;
    logic                restart;
    logic                tick;
    logic                emit;
    logic signed [W-1:0] i3_next;
    logic signed [W-1:0] result;
    logic signed [W-1:0] scaled;
    logic [OUT_W-1:0]    dout_q;

    function automatic logic [OUT_W-1:0] sat_word(input logic signed [W-1:0] v);
        logic signed [W-1:0] hi_lim;
        logic signed [W-1:0] lo_lim;
        hi_lim = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
        lo_lim = -hi_lim - W'(1);
        if (v > hi_lim) begin
            return {1'b0, {(OUT_W-1){1'b1}}};
        end else if (v < lo_lim) begin
            return {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            return v[OUT_W-1:0];
        end
    endfunction

    sinc3_ctrl #(
        .RATIO0 (RATIO0),
        .RATIO1 (RATIO1)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .rate_sel  (rate_sel),
        .fsync     (fsync),
        .accept_o  (accept),
        .restart_o (restart),
        .tick_o    (tick),
        .emit_o    (emit),
        .drdy_o    (drdy),
        .dvalid_o  (dvalid)
    );

    sinc3_integrator #(
        .W      (W),
        .STAGES (ORDER)
    ) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .en     (accept),
        .bit_i  (mod_bit),
        .last_o (i3_next)
    );

    sinc3_comb #(
        .W      (W),
        .STAGES (ORDER)
    ) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .load  (tick),
        .i3_in (i3_next),
        .emit  (emit),
        .res_o (result)
    );

    always_comb begin
        scaled = rate_sel ? (result >>> SH1) : (result >>> SH0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (emit) begin
            dout_q <= sat_word(scaled);
        end
    end

    assign dout = dout_q;

    // R4: the word changes only together with the ready strobe
    a_r4_dout_only_on_drdy: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy |-> $stable(dout));

    // R1: nothing is flagged ready while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!drdy && !dvalid && dout == '0));

endmodule

// File: tb/sinc3_decimator_tb.sv
module sinc3_decimator_tb;

    localparam int R    = 512;
    localparam int NMAX = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_en;
    logic        mod_bit;
    logic        rate_sel;
    logic        fsync;
    logic [15:0] dout;
    logic        drdy;
    logic        dvalid;

    always #5 clk = ~clk;

    sinc3_decimator u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .mod_bit   (mod_bit),
        .rate_sel  (rate_sel),
        .fsync     (fsync),
        .dout      (dout),
        .drdy      (drdy),
        .dvalid    (dvalid)
    );

    typedef struct {
        longint d;
        logic   v;
    } exp_t;

    exp_t   expq [$];
    longint xh  [NMAX];
    longint s1h [NMAX];
    longint s2h [NMAX];
    longint s3h [NMAX];
    int     m;
    int     checks;
    int     fails;
    longint last_word;
    logic [15:0] lfsr;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic longint geta(input int sel, input int i);
        if (i < 1) return 0;
        case (sel)
            0: return xh[i % NMAX];
            1: return s1h[i % NMAX];
            2: return s2h[i % NMAX];
            default: return s3h[i % NMAX];
        endcase
    endfunction

    // reference: three cascaded 512-wide boxcar sums (R3)
    function automatic bit model_push(input bit b);
        longint v;
        m++;
        xh[m % NMAX]  = b ? 64'sd1 : -64'sd1;
        s1h[m % NMAX] = geta(1, m - 1) + geta(0, m) - geta(0, m - R);
        s2h[m % NMAX] = geta(2, m - 1) + geta(1, m) - geta(1, m - R);
        s3h[m % NMAX] = geta(3, m - 1) + geta(2, m) - geta(2, m - R);
        if (m % R == 0) begin
            v = s3h[m % NMAX] >>> 12;
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            expq.push_back('{d: v, v: ((m / R) >= 3)});
            return 1'b1;
        end
        return 1'b0;
    endfunction

    // driver: one strobe, then the checked latency at decimation points (R4)
    task automatic send(input bit b, input int gap);
        bit point;
        sample_en = 1'b1;
        mod_bit   = b;
        point     = model_push(b);
        @(negedge clk);
        sample_en = 1'b0;
        if (point) begin
            chk(drdy == 1'b0, "R4 drdy early", longint'(drdy), 0);
            @(negedge clk);
            chk(drdy == 1'b1, "R4 drdy latency", longint'(drdy), 1);
        end
        repeat (gap) @(negedge clk);
    endtask

    function automatic int next_gap();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr[1:0] == 2'b11 ? 2 : lfsr[0]);
    endfunction

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_sync();
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        m = 0;
        chk(dvalid == 1'b0, "R6 valid after sync", longint'(dvalid), 0);
    endtask

    // monitor: pop and compare each emitted word (R3, R6)
    always @(negedge clk) begin
        if (rst_n && drdy) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected word", longint'($signed(dout)), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(longint'($signed(dout)) == e.d, "R3 word", longint'($signed(dout)), e.d);
                chk(dvalid == e.v, "R6 valid flag", longint'(dvalid), longint'(e.v));
                last_word = longint'($signed(dout));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        checks = 0; fails = 0; m = 0; lfsr = 16'hACE1; last_word = 0;
        rst_n = 1'b0; sample_en = 1'b0; mod_bit = 1'b0; rate_sel = 1'b0; fsync = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(dout == 16'h0, "R1 dout", longint'(dout), 0);
        chk(drdy == 1'b0, "R1 drdy", longint'(drdy), 0);
        chk(dvalid == 1'b0, "R1 dvalid", longint'(dvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dvalid == 1'b0, "R1 dvalid after release", longint'(dvalid), 0);

        // R2: all ones saturates high
        do_sync();
        for (int i = 0; i < 5 * R; i++) send(1'b1, 0);
        drain();
        chk(last_word == 32767, "R2 ones gain", last_word, 32767);

        // R2: all zeros reaches the negative limit
        do_sync();
        for (int i = 0; i < 5 * R; i++) send(1'b0, 0);
        drain();
        chk(last_word == -32768, "R2 zeros gain", last_word, -32768);

        // R3, R8: pseudo-random bits with idle gaps
        do_sync();
        for (int i = 0; i < 4 * R; i++) begin
            int g;
            g = next_gap();
            send(lfsr[7], g);
        end
        // unsynchronised step to ones, model tracks slow settling
        for (int i = 0; i < 4 * R; i++) send(1'b1, 0);
        drain();

        // R5: sync together with a strobe drops that strobe
        fsync = 1'b1; sample_en = 1'b1; mod_bit = 1'b1;
        @(negedge clk);
        fsync = 1'b0; sample_en = 1'b0;
        m = 0;
        chk(dvalid == 1'b0, "R5 sync with strobe", longint'(dvalid), 0);
        for (int i = 0; i < 3 * R; i++) send((i % 4) != 0, next_gap());
        drain();

        // R7: rate_sel toggle restarts the filter
        rate_sel = 1'b1;
        @(negedge clk);
        m = 0;
        chk(dvalid == 1'b0, "R7 valid after rate change", longint'(dvalid), 0);
        for (int i = 0; i < 3 * R; i++) send(((i / 64) % 2) == 0, 0);
        drain();
        chk(dvalid == 1'b1, "R7 valid on third word", longint'(dvalid), 1);

        chk(expq.size() == 0, "R4 words outstanding", longint'(expq.size()), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule